// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-data-rate SDRAM from the moment reset is released until the memory is ready for ordinary traffic. It holds the clock enable high, masks the data pins and drives no-operation commands for a long stabilisation window. It then closes every bank, runs a burst of auto-refresh cycles and loads the mode register with a value supplied by the surrounding controller. When the mode-load wait has elapsed it raises `init_done` and keeps the bus idle. The normal-operation controller then takes over the pins.

Every delay is expressed in nanoseconds and converted to whole clock cycles from a clock-period parameter, always rounding up. The controller reads only `init_done` and supplies `mode_value`, which is placed on the address pins during the mode-register load.

The states, in order, are HOLD (stabilisation window) -> PRECHARGE (one cycle) -> WAIT_RP -> REFRESH (one cycle) -> WAIT_RFC. WAIT_RFC returns to REFRESH until the refresh tally reaches its count, and otherwise moves on to LOAD_MODE (one cycle) -> WAIT_MRD -> DONE. DONE is terminal. Reset returns the machine to HOLD from any state.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset and for exactly HOLD cycles after its release, CKE is high, every DQM bit is high and the command {cs_n,ras_n,cas_n,we_n} is NOP = 4'b0111. HOLD is ceil(HOLD_NS*1000/CLK_PERIOD_PS), which is 40000 at the defaults.
- R2: In cycle HOLD after reset release the command is precharge = 4'b0010, with address bit 10 high and every other address bit and the bank address zero.
- R3: The first auto-refresh comes exactly RP cycles after the precharge. RP is ceil(T_RP_NS*1000/CLK_PERIOD_PS) with a floor of 2, which is 4 at the defaults.
- R4: Exactly REFRESH_COUNT (default 8) auto-refresh commands are issued, each encoded 4'b0001 with address and bank zero and CKE high.
- R5: Successive auto-refreshes, and the last refresh and the mode load, are spaced exactly RFC cycles apart. RFC is ceil(T_RFC_NS*1000/CLK_PERIOD_PS) with a floor of 2, which is 14 at the defaults.
- R6: The mode-register load is encoded 4'b0000, with `mode_value` on the address pins and the bank address zero. No precharge or refresh follows it.
- R7: `init_done` is low until exactly MRD cycles (default 2) after the mode load, rises once, and then stays high until the next reset.
- R8: Every cycle that carries none of the commands above drives NOP, including every cycle after `init_done` rises.
- R9: A reset asserted partway through the sequence returns the block to the start of R1. The whole sequence, including the full hold window, is then repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_value | input | ADDR_W | Value placed on the address pins by the mode-register load |
| sdram_cke | output | 1 | Clock enable to the memory |
| sdram_cs_n | output | 1 | Chip select, active low |
| sdram_ras_n | output | 1 | Row strobe, active low |
| sdram_cas_n | output | 1 | Column strobe, active low |
| sdram_we_n | output | 1 | Write enable, active low |
| sdram_addr | output | ADDR_W | Address pins |
| sdram_ba | output | BANK_W | Bank address |
| sdram_dqm | output | DQM_W | Data mask lanes |
| init_done | output | 1 | High once initialization is complete |

## Verification
The hardest situation to reach is a reset that lands in the middle of the refresh burst. At that point the refresh tally and the wait timer both hold non-zero values, and both must restart cleanly. The bench counts cycles from reset release and asserts reset a few cycles after the fourth refresh, with the queue loaded with exactly the commands expected before the cut. It then confirms that the queue is empty and that a later run repeats the full 40000-cycle hold window. The rounding rule is exercised as well: the default precharge and refresh delays are not whole multiples of the 5 ns clock, so a truncating conversion would shift every command the scoreboard checks.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RFC,
        ST_LOAD_MODE,
        ST_WAIT_MRD,
        ST_DONE
    } init_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdram_cmd_t;

    localparam sdram_cmd_t CMD_NOP       = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdram_cmd_t CMD_PRECHARGE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdram_cmd_t CMD_REFRESH   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdram_cmd_t CMD_LOAD_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // Whole clock cycles covering a delay in ns, rounded up.
    function automatic int unsigned ns_to_cycles(input int unsigned delay_ns,
                                                 input int unsigned period_ps);
        return (delay_ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int unsigned at_least(input int unsigned value,
                                             input int unsigned floor_val);
        return (value < floor_val) ? floor_val : value;
    endfunction

    function automatic int unsigned larger(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_wait_timer.sv
// Free-running cycle counter that restarts at zero whenever the sequencer
// changes state; saturates so a terminal state never wraps it.
module init_wait_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [WIDTH-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (count != '1) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/init_refresh_tally.sv
// Counts issued refresh commands; flags when the required number is reached.
module init_refresh_tally #(
    parameter int TARGET = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump,
    output logic reached
);

    localparam int TW = $clog2(TARGET + 1);

    logic [TW-1:0] tally;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally <= '0;
        end else if (bump && (tally != TW'(TARGET))) begin
            tally <= tally + 1'b1;
        end
    end

    assign reached = (tally == TW'(TARGET));

endmodule

// File: rtl/init_cmd_encoder.sv
// Decodes the sequencer state into the memory pin values.
module init_cmd_encoder
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W            = 12,
    parameter int BANK_W            = 2,
    parameter int DQM_W             = 2,
    parameter int PRECHARGE_ALL_BIT = 10
) (
    input  init_state_e       state,
    input  logic [ADDR_W-1:0] mode_value,
    output sdram_cmd_t        cmd,
    output logic              cke,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic [DQM_W-1:0]  dqm
);

    always_comb begin
        cmd  = CMD_NOP;
        cke  = 1'b1;
        addr = '0;
        ba   = '0;
        dqm  = '1;
        unique case (state)
            ST_PRECHARGE: begin
                cmd                     = CMD_PRECHARGE;
                addr[PRECHARGE_ALL_BIT] = 1'b1;
            end
            ST_REFRESH: begin
                cmd = CMD_REFRESH;
            end
            ST_LOAD_MODE: begin
                cmd  = CMD_LOAD_MODE;
                addr = mode_value;
            end
            ST_HOLD, ST_WAIT_RP, ST_WAIT_RFC, ST_WAIT_MRD, ST_DONE: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_PERIOD_PS     = 5000,
    parameter int HOLD_NS           = 200000,
    parameter int T_RP_NS           = 18,
    parameter int T_RFC_NS          = 66,
    parameter int REFRESH_COUNT     = 8,
    parameter int MRD_CYCLES        = 2,
    parameter int ADDR_W            = 12,
    parameter int BANK_W            = 2,
    parameter int DQM_W             = 2,
    parameter int PRECHARGE_ALL_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_value,
    output logic              sdram_cke,
    output logic              sdram_cs_n,
    output logic              sdram_ras_n,
    output logic              sdram_cas_n,
    output logic              sdram_we_n,
    output logic [ADDR_W-1:0] sdram_addr,
    output logic [BANK_W-1:0] sdram_ba,
    output logic [DQM_W-1:0]  sdram_dqm,
    output logic              init_done
);

    // Cycle counts, rounded up; spacing waits need at least two cycles
    // because each command occupies its own state.
    localparam int HOLD_CYC = int'(at_least(ns_to_cycles(HOLD_NS, CLK_PERIOD_PS), 1));
    localparam int RP_CYC   = int'(at_least(ns_to_cycles(T_RP_NS, CLK_PERIOD_PS), 2));
    localparam int RFC_CYC  = int'(at_least(ns_to_cycles(T_RFC_NS, CLK_PERIOD_PS), 2));
    localparam int MRD_CYC  = int'(at_least(MRD_CYCLES, 2));
    localparam int LONGEST  = int'(larger(larger(HOLD_CYC, RP_CYC), larger(RFC_CYC, MRD_CYC)));
    localparam int CNT_W    = $clog2(LONGEST + 1);

    init_state_e      state_q;
    init_state_e      state_d;
    logic [CNT_W-1:0] wait_cnt;
    logic             refresh_all;
    sdram_cmd_t       cmd;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:
                if (wait_cnt == CNT_W'(HOLD_CYC - 1)) state_d = ST_PRECHARGE;
            ST_PRECHARGE:
                state_d = ST_WAIT_RP;
            ST_WAIT_RP:
                if (wait_cnt == CNT_W'(RP_CYC - 2)) state_d = ST_REFRESH;
            ST_REFRESH:
                state_d = ST_WAIT_RFC;
            ST_WAIT_RFC:
                if (wait_cnt == CNT_W'(RFC_CYC - 2))
                    state_d = refresh_all ? ST_LOAD_MODE : ST_REFRESH;
            ST_LOAD_MODE:
                state_d = ST_WAIT_MRD;
            ST_WAIT_MRD:
                if (wait_cnt == CNT_W'(MRD_CYC - 2)) state_d = ST_DONE;
            ST_DONE:
                state_d = ST_DONE;
        endcase
    end

    init_wait_timer #(
        .WIDTH (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .count   (wait_cnt)
    );

    init_refresh_tally #(
        .TARGET (REFRESH_COUNT)
    ) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump    (state_q == ST_REFRESH),
        .reached (refresh_all)
    );

    init_cmd_encoder #(
        .ADDR_W            (ADDR_W),
        .BANK_W            (BANK_W),
        .DQM_W             (DQM_W),
        .PRECHARGE_ALL_BIT (PRECHARGE_ALL_BIT)
    ) u_enc (
        .state      (state_q),
        .mode_value (mode_value),
        .cmd        (cmd),
        .cke        (sdram_cke),
        .addr       (sdram_addr),
        .ba         (sdram_ba),
        .dqm        (sdram_dqm)
    );

    assign sdram_cs_n  = cmd.cs_n;
    assign sdram_ras_n = cmd.ras_n;
    assign sdram_cas_n = cmd.cas_n;
    assign sdram_we_n  = cmd.we_n;
    assign init_done   = (state_q == ST_DONE);

endmodule

// File: rtl/sdram_init_seq_checker.sv
module sdram_init_seq_checker #(
    parameter int ADDR_W            = 12,
    parameter int BANK_W            = 2,
    parameter int DQM_W             = 2,
    parameter int REFRESH_COUNT     = 8,
    parameter int PRECHARGE_ALL_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mode_value,
    input logic              sdram_cke,
    input logic              sdram_cs_n,
    input logic              sdram_ras_n,
    input logic              sdram_cas_n,
    input logic              sdram_we_n,
    input logic [ADDR_W-1:0] sdram_addr,
    input logic [BANK_W-1:0] sdram_ba,
    input logic [DQM_W-1:0]  sdram_dqm,
    input logic              init_done
);

    logic [3:0] pins;
    logic       is_nop, is_pre, is_ref, is_mrs;
    logic [15:0] ref_seen;
    logic        mrs_seen;

    assign pins   = {sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);
    assign is_mrs = (pins == 4'b0000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_seen <= '0;
            mrs_seen <= 1'b0;
        end else begin
            if (is_ref && ref_seen != '1) ref_seen <= ref_seen + 1'b1;
            if (is_mrs) mrs_seen <= 1'b1;
        end
    end

    p_cke_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sdram_cke && (&sdram_dqm));

    p_precharge_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sdram_addr[PRECHARGE_ALL_BIT] && (sdram_ba == '0));

    p_refresh_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (ref_seen == 16'(REFRESH_COUNT)));

    p_cmd_then_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |=> is_nop);

    p_mode_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (sdram_addr == mode_value) && (sdram_ba == '0));

    p_nothing_after_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_seen |-> !is_pre && !is_ref && !is_mrs);

    p_done_after_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> mrs_seen);

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_legal_encoding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop || is_pre || is_ref || is_mrs);

    p_idle_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_seq_checker #(
    .ADDR_W            (ADDR_W),
    .BANK_W            (BANK_W),
    .DQM_W             (DQM_W),
    .REFRESH_COUNT     (REFRESH_COUNT),
    .PRECHARGE_ALL_BIT (PRECHARGE_ALL_BIT)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_value  (mode_value),
    .sdram_cke   (sdram_cke),
    .sdram_cs_n  (sdram_cs_n),
    .sdram_ras_n (sdram_ras_n),
    .sdram_cas_n (sdram_cas_n),
    .sdram_we_n  (sdram_we_n),
    .sdram_addr  (sdram_addr),
    .sdram_ba    (sdram_ba),
    .sdram_dqm   (sdram_dqm),
    .init_done   (init_done)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;

    // Expected counts from the requirements at default parameters (5 ns clock):
    // hold 200000 ns -> 40000, precharge wait 18 ns -> 4, refresh gap 66 ns -> 14.
    localparam int H_CYC   = 40000;
    localparam int RP_CYC  = 4;
    localparam int RFC_CYC = 14;
    localparam int MRD_CYC = 2;
    localparam int N_REF   = 8;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] MRS = 4'b0000;

    typedef struct {
        int         cyc;
        logic [3:0] cmd;
        logic [11:0] addr;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mode_value = 12'h033;
    logic        sdram_cke, sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n;
    logic [11:0] sdram_addr;
    logic [1:0]  sdram_ba;
    logic [1:0]  sdram_dqm;
    logic        init_done;

    int   checks = 0;
    int   errors = 0;
    int   k = 0;
    int   done_cyc = -1;
    int   done_drops = 0;
    int   pin_faults = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    sdram_init_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_value  (mode_value),
        .sdram_cke   (sdram_cke),
        .sdram_cs_n  (sdram_cs_n),
        .sdram_ras_n (sdram_ras_n),
        .sdram_cas_n (sdram_cas_n),
        .sdram_we_n  (sdram_we_n),
        .sdram_addr  (sdram_addr),
        .sdram_ba    (sdram_ba),
        .sdram_dqm   (sdram_dqm),
        .init_done   (init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Driver: queue the commands one run is expected to produce.
    task automatic push_run(input logic [11:0] mode, input int n_ref, input bit with_mode);
        exp_t e;
        e = '{cyc: H_CYC, cmd: PRE, addr: 12'h400, tag: "R1/R2"};
        sb_q.push_back(e);
        for (int i = 0; i < n_ref; i++) begin
            e = '{cyc: H_CYC + RP_CYC + i * RFC_CYC, cmd: REF, addr: 12'h000,
                  tag: (i == 0) ? "R3/R4" : "R4/R5"};
            sb_q.push_back(e);
        end
        if (with_mode) begin
            e = '{cyc: H_CYC + RP_CYC + n_ref * RFC_CYC, cmd: MRS, addr: mode,
                  tag: "R5/R6"};
            sb_q.push_back(e);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    // Monitor: compare every non-idle command against the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] pins;
            pins = {sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n};
            if (!sdram_cke || sdram_dqm != 2'b11) pin_faults++;
            if (pins != NOP) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected command at cycle", k, -1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(k == e.cyc, e.tag, "command cycle", k, e.cyc);
                    check(pins == e.cmd && sdram_addr == e.addr && sdram_ba == 2'b00,
                          e.tag, "command pins/addr",
                          int'({pins, sdram_addr}), int'({e.cmd, e.addr}));
                end
            end
            if (init_done && done_cyc < 0) done_cyc = k;
            if (!init_done && done_cyc >= 0) done_drops++;
        end
    end

    task automatic wait_k(input int n);
        while (k < n) @(negedge clk);
    endtask

    task automatic full_run(input logic [11:0] mode);
        int exp_done;
        exp_done = H_CYC + RP_CYC + N_REF * RFC_CYC + MRD_CYC;
        mode_value = mode;
        done_cyc = -1;
        done_drops = 0;
        push_run(mode, N_REF, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        wait_k(exp_done + 20);
        @(negedge clk);
        check(done_cyc == exp_done, "R7", "init_done rise cycle", done_cyc, exp_done);
        check(done_drops == 0, "R7", "init_done falls after rising", done_drops, 0);
        check(sb_q.size() == 0, "R4", "commands still outstanding", sb_q.size(), 0);
        check({sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n} == NOP, "R8",
              "idle after done", int'({sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n}),
              int'(NOP));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", "run did not complete, cycles", 190000, 0);
        finish_run();
    end

    initial begin
        // R1: state held during reset.
        repeat (4) @(negedge clk);
        check(sdram_cke == 1'b1 && sdram_dqm == 2'b11, "R1", "cke/dqm in reset",
              int'({sdram_cke, sdram_dqm}), 7);
        check({sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n} == NOP, "R1",
              "command in reset", int'({sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n}),
              int'(NOP));
        check(init_done == 1'b0, "R7", "init_done in reset", init_done, 0);

        // Run A: full sequence.
        full_run(12'h033);

        // Run B: R9 reset a few cycles after the fourth refresh.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        mode_value = 12'h0A5;
        push_run(12'h0A5, 4, 1'b0);
        rst_n = 1'b1;
        wait_k(H_CYC + RP_CYC + 3 * RFC_CYC + 5);
        rst_n = 1'b0;
        @(negedge clk);
        check(sb_q.size() == 0, "R9", "partial-run commands outstanding", sb_q.size(), 0);
        check(init_done == 1'b0, "R9", "init_done after mid reset", init_done, 0);
        check({sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n} == NOP, "R9",
              "command after mid reset",
              int'({sdram_cs_n, sdram_ras_n, sdram_cas_n, sdram_we_n}), int'(NOP));
        sb_q.delete();
        repeat (2) @(negedge clk);

        // Run C: full sequence again after the interrupted one (R9, R6 new value).
        full_run(12'h237);

        check(pin_faults == 0, "R1", "cycles with cke low or dqm not all high",
              pin_faults, 0);
        finish_run();
    end

endmodule